// File: doc/BRIEF.md
# Program Memory Byte Fetch Unit

This unit lets a processor core read single bytes from a program memory that is organised as 16-bit words. A byte pointer comes in with each command. Bits above bit 0 of that pointer form the word address. Bit 0 chooses which half of the returned word is delivered. An optional extension byte can sit above the pointer, which lets the unit reach a program memory larger than 64 KB.

The core presents a command together with the current pointer and extension values. The unit drives the memory word address and a one-cycle strobe in that same cycle. The memory answers one clock later. In that next cycle the unit raises `done`, shows the selected byte, and shows the updated pointer and extension values, which the core writes back.

There are four commands:
- a plain read, which leaves the pointer as it was;
- a read that then steps the pointer by one;
- a word-write address step, which raises a write strobe and steps the pointer by two;
- an idle code, which does nothing.

When the extension is enabled, each step carries from the pointer into the extension.

Top module: `pmem_byte_fetch`

## Requirements
- R1: After reset, `done`, `wr_err`, `byte_out`, `z_out` and `ext_out` are all zero.
- R2: While a read or write command is presented, `mem_addr` bits [14:0] equal `z_in[15:1]`, and the strobe appears in that same cycle.
- R3: On a completed read, `byte_out` is bits [7:0] of the returned word when the pointer bit 0 was 0, and bits [15:8] when it was 1.
- R4: With `ext_en` = 1, `mem_addr` bits [22:15] equal `ext_in`. With `ext_en` = 0, those bits are zero.
- R5: Command code 2'b01 (plain read) returns `z_out` and `ext_out` equal to the values presented with the command.
- R6: Command code 2'b10 (read with step) fetches at the pointer value before the step, then returns that pointer plus one.
- R7: When `ext_en` = 1, a step treats {ext, z} as one 24-bit value, so a carry out of z increments the extension. When `ext_en` = 0, z wraps at 16 bits and the extension is returned unchanged.
- R8: Command code 2'b11 (word write) raises `mem_wr` and not `mem_rd`. It addresses memory with the pointer value before the step and returns that pointer plus two.
- R9: A word write with pointer bit 0 set raises `wr_err` together with `done`. The word address ignores bit 0, and the step is still plus two from the presented value.
- R10: `done` pulses exactly one cycle after each `mem_rd` or `mem_wr` strobe and at no other time. Command code 2'b00 raises no strobe and leaves `z_out` and `ext_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd | input | 2 | 00 idle, 01 read, 10 read and step by one, 11 word write and step by two |
| ext_en | input | 1 | Use the extension byte above the pointer |
| z_in | input | 16 | Byte pointer presented with the command |
| ext_in | input | 8 | Extension byte presented with the command |
| mem_rdata | input | 16 | Word returned by memory one cycle after `mem_rd` |
| mem_addr | output | 23 | Memory word address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| done | output | 1 | Command complete; result outputs valid |
| byte_out | output | 8 | Selected byte of the returned word |
| z_out | output | 16 | Updated pointer |
| ext_out | output | 8 | Updated extension byte |
| wr_err | output | 1 | Word write was issued with an odd pointer |

## Verification
Reads at even and odd pointers show whether the byte lane follows bit 0. Reads with the extension on and off, each with a nonzero extension byte, show whether the upper address bits are gated. Steps at the pointer edges 0x00FF, 0xFFFF and 0xFFFE tell a 16-bit wrap apart from a 24-bit carry into the extension. Even and odd word writes separate the plus-two step and the error flag from the read path, and back-to-back commands with idle gaps check that exactly one completion comes out per strobe.

// File: rtl/pmem_byte_fetch.sv
module pmem_byte_fetch #(
  parameter int ZW = 16,
  parameter int EW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cmd,
  input  logic                ext_en,
  input  logic [ZW-1:0]       z_in,
  input  logic [EW-1:0]       ext_in,
  input  logic [15:0]         mem_rdata,
  output logic [ZW+EW-2:0]    mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                done,
  output logic [7:0]          byte_out,
  output logic [ZW-1:0]       z_out,
  output logic [EW-1:0]       ext_out,
  output logic                wr_err
);
  localparam int PW = ZW + EW;
  localparam logic [1:0] C_RD  = 2'b01;
  localparam logic [1:0] C_RDI = 2'b10;
  localparam logic [1:0] C_WR  = 2'b11;

  logic          is_rd, is_wr;
  logic [1:0]    step;
  logic [PW-1:0] wide_sum;
  logic [ZW-1:0] narrow_sum;
  logic          rd_q, hi_q;

  assign is_rd    = (cmd == C_RD) || (cmd == C_RDI);
  assign is_wr    = (cmd == C_WR);
  assign mem_rd   = is_rd;
  assign mem_wr   = is_wr;
  assign mem_addr = {(ext_en ? ext_in : {EW{1'b0}}), z_in[ZW-1:1]};

  assign step       = (cmd == C_RDI) ? 2'd1 : (is_wr ? 2'd2 : 2'd0);
  assign wide_sum   = {ext_in, z_in} + PW'(step);
  assign narrow_sum = z_in + ZW'(step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      rd_q    <= 1'b0;
      hi_q    <= 1'b0;
      wr_err  <= 1'b0;
      z_out   <= '0;
      ext_out <= '0;
    end else begin
      done   <= is_rd || is_wr;
      rd_q   <= is_rd;
      hi_q   <= z_in[0];
      wr_err <= is_wr && z_in[0];
      if (is_rd || is_wr) begin
        z_out   <= ext_en ? wide_sum[ZW-1:0] : narrow_sum;
        ext_out <= ext_en ? wide_sum[PW-1:ZW] : ext_in;
      end
    end
  end

  assign byte_out = !rd_q ? 8'h00 : (hi_q ? mem_rdata[15:8] : mem_rdata[7:0]);
endmodule

// File: rtl/pmem_byte_fetch_chk.sv
module pmem_byte_fetch_chk #(
  parameter int ZW = 16,
  parameter int EW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd,
  input logic             ext_en,
  input logic [ZW-1:0]    z_in,
  input logic [EW-1:0]    ext_in,
  input logic [ZW+EW-2:0] mem_addr,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             done,
  input logic [ZW-1:0]    z_out,
  input logic [EW-1:0]    ext_out,
  input logic             wr_err
);
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |=> done);

  a_r10_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rd || mem_wr));

  a_r9_odd_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && z_in[0]) |=> (wr_err && done));

  a_r9_flag_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(mem_wr));

  a_r5_plain_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && cmd == 2'b01) |=> (z_out == $past(z_in) && ext_out == $past(ext_in)));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b00) |=> ($stable(z_out) && $stable(ext_out)));

  a_r4_ext_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && (mem_rd || mem_wr)) |-> (mem_addr[ZW+EW-2:ZW-1] == '0));
endmodule

bind pmem_byte_fetch pmem_byte_fetch_chk #(.ZW(ZW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .ext_en(ext_en), .z_in(z_in),
  .ext_in(ext_in), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .done(done), .z_out(z_out), .ext_out(ext_out), .wr_err(wr_err)
);

// File: tb/pmem_byte_fetch_tb.sv
module pmem_byte_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic        ext_en = 1'b0;
  logic [15:0] z_in = '0;
  logic [7:0]  ext_in = '0;
  logic [15:0] mem_rdata = '0;
  logic [22:0] mem_addr;
  logic        mem_rd, mem_wr, done, wr_err;
  logic [7:0]  byte_out, ext_out;
  logic [15:0] z_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    bit          is_rd;
    logic [7:0]  b;
    logic [15:0] z;
    logic [7:0]  e;
    bit          err;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  pmem_byte_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .ext_en(ext_en), .z_in(z_in),
    .ext_in(ext_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .done(done), .byte_out(byte_out),
    .z_out(z_out), .ext_out(ext_out), .wr_err(wr_err)
  );

  function automatic logic [15:0] pat(input logic [22:0] a);
    return a[15:0] ^ {a[22:16], 9'h0AB};
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic en, input logic [15:0] z,
                       input logic [7:0] e, input string req);
    exp_t x;
    logic [22:0] wa;
    logic [23:0] sum;
    logic [1:0]  st;
    @(negedge clk);
    cmd = c; ext_en = en; z_in = z; ext_in = e;
    wa = {(en ? e : 8'h00), z[15:1]};
    st = (c == 2'b10) ? 2'd1 : ((c == 2'b11) ? 2'd2 : 2'd0);
    x.is_rd = (c == 2'b01) || (c == 2'b10);
    x.b   = z[0] ? pat(wa)[15:8] : pat(wa)[7:0];
    sum   = {e, z} + 24'(st);
    x.z   = en ? sum[15:0] : z + 16'(st);
    x.e   = en ? sum[23:16] : e;
    x.err = (c == 2'b11) && z[0];
    x.req = req;
    #1;
    chk({req, "/R2 addr"}, 32'(mem_addr), 32'(wa));
    chk({req, "/R8 strobes"}, {30'd0, mem_rd, mem_wr}, {30'd0, x.is_rd, c == 2'b11});
    sb.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd = 2'b00;
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected done actual=1 expected=0");
      end else begin
        exp_t x;
        x = sb.pop_front();
        if (x.is_rd) chk({x.req, "/R3 byte"}, 32'(byte_out), 32'(x.b));
        chk({x.req, " z_out"}, 32'(z_out), 32'(x.z));
        chk({x.req, " ext_out"}, 32'(ext_out), 32'(x.e));
        chk({x.req, "/R9 err"}, 32'(wr_err), 32'(x.err));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 done", 32'(done), 0);
    chk("R1 err", 32'(wr_err), 0);
    chk("R1 byte", 32'(byte_out), 0);
    chk("R1 z", 32'(z_out), 0);
    chk("R1 ext", 32'(ext_out), 0);
    rst_n = 1'b1;
    idle(2);
    issue(2'b01, 1'b0, 16'h1234, 8'h3C, "R3 even R5");
    idle(1);
    issue(2'b01, 1'b0, 16'h1235, 8'h3C, "R3 odd R5");
    issue(2'b01, 1'b1, 16'h8001, 8'h03, "R4 ext on");
    issue(2'b01, 1'b0, 16'h8001, 8'h03, "R4 ext off");
    issue(2'b10, 1'b0, 16'h00FF, 8'h11, "R6 step");
    issue(2'b10, 1'b1, 16'hFFFF, 8'h05, "R7 carry");
    issue(2'b10, 1'b0, 16'hFFFF, 8'h05, "R7 wrap");
    idle(2);
    issue(2'b11, 1'b0, 16'h2000, 8'h00, "R8 write");
    issue(2'b11, 1'b0, 16'h2001, 8'h00, "R9 odd write");
    issue(2'b11, 1'b1, 16'hFFFE, 8'h07, "R7 R8 write carry");
    issue(2'b10, 1'b1, 16'h4567, 8'h22, "R6 ext step");
    idle(3);
    @(negedge clk);
    cmd = 2'b00; z_in = 16'hABCD; ext_in = 8'h99;
    #1;
    chk("R10 idle rd", 32'(mem_rd), 0);
    chk("R10 idle wr", 32'(mem_wr), 0);
    idle(2);
    #3;
    chk("R10 idle z held", 32'(z_out), 32'h4568);
    chk("R10 idle ext held", 32'(ext_out), 32'h22);
    chk("R10 all done", 32'(sb.size()), 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule